// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block gathers a set of external interrupt pins into one memory-mapped controller. Each pin passes through a two-stage synchronizer into the block's clock domain. Each pin then runs through its own sense lane, which software configures to react to a low level, a high level, a rising edge, a falling edge or either edge. A matching event sets that pin's bit in a detect latch. The latch holds the bit until software writes a one to it. The bit sets again at once if a level condition is still present.

A per-pin enable mask decides which latched events reach the outside. Software sets mask bits through one register and clears them through another. Each pin has its own interrupt output, which is high while its detect bit and its enable bit are both set. A read-only request view shows the same gated vector. A monitor view shows the synchronized pin levels.

The register port is a plain 32-bit access port. It has separate read and write strobes, a 12-bit byte address and read data that is registered. It applies no back-pressure, so it accepts one access in every cycle. The block has no streaming data path, so there are no valid/ready handshakes. Bit n of every vector register belongs to pin n.

Top module: `ext_irq_sense_ctrl`

## Requirements
- R1: The monitor register at offset 0x104 returns the pin levels after two synchronizer flops. A pin change driven just after a clock edge first appears in a read that captures on the third following edge.
- R2: The sense register of pin n is at offset 0x180 + 4*n. Bits 5:0 hold the code and bits 31:6 read as zero. Code 0x01 selects low level, 0x02 high level, 0x04 falling edge, 0x08 rising edge and 0x0C both edges. Any other code, including 0, detects nothing.
- R3: In a level mode, the detect bit sets while the level is active. A clear written while the level is still active leaves the bit set, because a set wins over a clear in the same cycle.
- R4: In an edge mode, the detect bit sets only on a new transition of the selected direction, and it stays clear after a clear until the next such transition.
- R5: Writing offset 0x100 clears each detect bit written as 1. Bits written as 0 are unchanged. Reading offset 0x100 returns the detect vector.
- R6: Writing offset 0x08 sets each enable bit written as 1. Bits written as 0 keep their value.
- R7: Writing offset 0x04 clears each enable bit written as 1. Reading offset 0x04 returns the enable mask.
- R8: Output irq_out[n] is detect[n] AND enable[n]. Reading offset 0x00 returns the same gated vector.
- R9: After reset, all enable bits, detect bits and sense codes are zero, and irq_out is zero.
- R10: Read data is captured on the edge where bus_rd is high. Reads return zero for unmapped offsets, misaligned offsets and sense slots at or above NUM_PINS.
- R11: Pins are independent: sensing on pin n changes only bit n of the detect vector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin | input | NUM_PINS | External interrupt pins, asynchronous |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | NUM_PINS | Per-pin interrupt outputs |

## Verification
The bound checker watches several rules on every clock cycle:
- No detect bit rises without a sense hit in the previous cycle.
- A write-one clear removes a bit unless a hit coincides with it.
- Enable set and enable clear writes take effect on the next cycle.
- A level hit never leaves its detect bit low on the next cycle.
- An output never rises without its enable bit.

Only the bench's scenarios can show the sense codes themselves, as it sweeps every listed code and several invalid ones across every pin. They also show the synchronizer's exact latency, the register addresses and read-back values, and the zero returned for unmapped offsets.

// File: rtl/irqs_pkg.sv
package irqs_pkg;

  localparam int unsigned BUS_AW  = 12;
  localparam int unsigned BUS_DW  = 32;
  localparam int unsigned SENSE_W = 6;

  localparam logic [BUS_AW-1:0] OFS_REQ    = 12'h000;
  localparam logic [BUS_AW-1:0] OFS_EN_CLR = 12'h004;
  localparam logic [BUS_AW-1:0] OFS_EN_SET = 12'h008;
  localparam logic [BUS_AW-1:0] OFS_DET    = 12'h100;
  localparam logic [BUS_AW-1:0] OFS_MON    = 12'h104;
  // sense slots occupy 0x180..0x1FC: address bits 11:7 equal 3
  localparam logic [4:0]        CFG_PAGE   = 5'b00011;

  typedef enum logic [2:0] {
    SNS_OFF,
    SNS_LOW,
    SNS_HIGH,
    SNS_FALL,
    SNS_RISE,
    SNS_BOTH
  } sense_e;

  function automatic sense_e decode_sense(input logic [SENSE_W-1:0] code);
    case (code)
      6'h01:   return SNS_LOW;
      6'h02:   return SNS_HIGH;
      6'h04:   return SNS_FALL;
      6'h08:   return SNS_RISE;
      6'h0C:   return SNS_BOTH;
      default: return SNS_OFF;
    endcase
  endfunction

endpackage

// File: rtl/irqs_sync.sv
module irqs_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/irqs_lane.sv
module irqs_lane
  import irqs_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [SENSE_W-1:0] cfg_wdata,
  input  logic               clr,
  input  logic               lvl,
  output logic [SENSE_W-1:0] cfg_q,
  output logic               hit,
  output logic               det
);

  logic   prev_q;
  logic   rise_ev;
  logic   fall_ev;
  sense_e mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      prev_q <= 1'b0;
      det    <= 1'b0;
    end else begin
      if (cfg_we) cfg_q <= cfg_wdata;
      prev_q <= lvl;
      // a new hit wins over a clear in the same cycle
      det    <= (det & ~clr) | hit;
    end
  end

  assign rise_ev = lvl & ~prev_q;
  assign fall_ev = ~lvl & prev_q;

  always_comb begin
    mode = decode_sense(cfg_q);
    case (mode)
      SNS_LOW:  hit = ~lvl;
      SNS_HIGH: hit = lvl;
      SNS_FALL: hit = fall_ev;
      SNS_RISE: hit = rise_ev;
      SNS_BOTH: hit = rise_ev | fall_ev;
      default:  hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/irqs_regs.sv
module irqs_regs
  import irqs_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             bus_wr,
  input  logic                             bus_rd,
  input  logic [BUS_AW-1:0]                bus_addr,
  input  logic [BUS_DW-1:0]                bus_wdata,
  output logic [BUS_DW-1:0]                bus_rdata,
  input  logic [NUM_PINS-1:0]              det_vec,
  input  logic [NUM_PINS-1:0]              mon_vec,
  input  logic [NUM_PINS-1:0][SENSE_W-1:0] cfg_all,
  output logic [NUM_PINS-1:0]              cfg_we,
  output logic [NUM_PINS-1:0]              det_clr,
  output logic [NUM_PINS-1:0]              en_vec
);

  logic             cfg_sel;
  logic [4:0]       slot;
  logic [BUS_DW-1:0] req_ext, en_ext, det_ext, mon_ext, cfg_ext, rd_mux;

  assign cfg_sel = (bus_addr[BUS_AW-1:7] == CFG_PAGE) && (bus_addr[1:0] == 2'b00);
  assign slot    = bus_addr[6:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_vec <= '0;
    end else if (bus_wr && bus_addr == OFS_EN_SET) begin
      en_vec <= en_vec | bus_wdata[NUM_PINS-1:0];
    end else if (bus_wr && bus_addr == OFS_EN_CLR) begin
      en_vec <= en_vec & ~bus_wdata[NUM_PINS-1:0];
    end
  end

  assign det_clr = (bus_wr && bus_addr == OFS_DET) ? bus_wdata[NUM_PINS-1:0] : '0;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_cfg_we
    localparam logic [4:0] SLOT_ID = 5'(i);
    assign cfg_we[i] = bus_wr && cfg_sel && (slot == SLOT_ID);
  end

  always_comb begin
    req_ext = '0;
    en_ext  = '0;
    det_ext = '0;
    mon_ext = '0;
    cfg_ext = '0;
    req_ext[NUM_PINS-1:0] = det_vec & en_vec;
    en_ext[NUM_PINS-1:0]  = en_vec;
    det_ext[NUM_PINS-1:0] = det_vec;
    mon_ext[NUM_PINS-1:0] = mon_vec;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (slot == 5'(i)) cfg_ext[SENSE_W-1:0] = cfg_all[i];
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_REQ:    rd_mux = req_ext;
      OFS_EN_CLR: rd_mux = en_ext;
      OFS_DET:    rd_mux = det_ext;
      OFS_MON:    rd_mux = mon_ext;
      default:    rd_mux = cfg_sel ? cfg_ext : '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

endmodule

// File: rtl/ext_irq_sense_ctrl.sv
module ext_irq_sense_ctrl
  import irqs_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] irq_pin,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [11:0]         bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic [NUM_PINS-1:0] irq_out
);

  logic [NUM_PINS-1:0]              lvl_vec;
  logic [NUM_PINS-1:0]              hit_vec;
  logic [NUM_PINS-1:0]              det_vec;
  logic [NUM_PINS-1:0]              en_vec;
  logic [NUM_PINS-1:0]              cfg_we;
  logic [NUM_PINS-1:0]              det_clr;
  logic [NUM_PINS-1:0][SENSE_W-1:0] cfg_all;

  irqs_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (irq_pin),
    .dout (lvl_vec)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_lane
    irqs_lane u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we[i]),
      .cfg_wdata(bus_wdata[SENSE_W-1:0]),
      .clr      (det_clr[i]),
      .lvl      (lvl_vec[i]),
      .cfg_q    (cfg_all[i]),
      .hit      (hit_vec[i]),
      .det      (det_vec[i])
    );
  end

  irqs_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .det_vec  (det_vec),
    .mon_vec  (lvl_vec),
    .cfg_all  (cfg_all),
    .cfg_we   (cfg_we),
    .det_clr  (det_clr),
    .en_vec   (en_vec)
  );

  assign irq_out = det_vec & en_vec;

endmodule

// File: rtl/irqs_checker.sv
module irqs_checker
  import irqs_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_wr,
  input logic [BUS_AW-1:0]   bus_addr,
  input logic [BUS_DW-1:0]   bus_wdata,
  input logic [NUM_PINS-1:0] det_q,
  input logic [NUM_PINS-1:0] en_q,
  input logic [NUM_PINS-1:0] hit_q,
  input logic [NUM_PINS-1:0] irq_out
);

  AST_DET_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((det_q & ~$past(det_q) & ~$past(hit_q)) == '0)); // R4

  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(hit_q) & ~det_q) == '0)); // R3

  AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_DET) |=>
      ((det_q & $past(bus_wdata[NUM_PINS-1:0]) & ~$past(hit_q)) == '0)); // R5

  AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_EN_SET) |=>
      ((en_q & $past(bus_wdata[NUM_PINS-1:0])) == $past(bus_wdata[NUM_PINS-1:0]))); // R6

  AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_EN_CLR) |=>
      ((en_q & $past(bus_wdata[NUM_PINS-1:0])) == '0)); // R7

  AST_OUT_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_out & ~en_q) == '0)); // R8

endmodule

bind ext_irq_sense_ctrl irqs_checker #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .det_q    (det_vec),
  .en_q     (en_vec),
  .hit_q    (hit_vec),
  .irq_out  (irq_out)
);

// File: tb/test_ext_irq_sense_ctrl.sv
`timescale 1ns/1ps
module test_ext_irq_sense_ctrl;

  localparam int unsigned NP = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] irq_pin = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] irq_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [5:0] codes [9] = '{6'h00, 6'h01, 6'h02, 6'h04, 6'h08, 6'h0C, 6'h03, 6'h10, 6'h3F};

  always #2.5 clk = ~clk;

  ext_irq_sense_ctrl #(.NUM_PINS(NP)) i_ext_irq_sense_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_pin(irq_pin),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); #1;
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic bit lvl_hit(input logic [5:0] c, input bit l);
    return (c == 6'h01 && !l) || (c == 6'h02 && l);
  endfunction

  function automatic bit edge_hit(input logic [5:0] c, input bit o, input bit n);
    return ((c == 6'h04 || c == 6'h0C) && o && !n) ||
           ((c == 6'h08 || c == 6'h0C) && !o && n);
  endfunction

  function automatic logic [11:0] cfg_addr(input int n);
    return 12'(12'h180 + 4 * n);
  endfunction

  initial begin
    #(5ns * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    tick(4);
    rst_n = 1'b1;
    tick(2);

    // R9 reset state
    rd(12'h000, v); chk("R9 req", v, 0);
    rd(12'h004, v); chk("R9 en", v, 0);
    rd(12'h100, v); chk("R9 det", v, 0);
    rd(12'h104, v); chk("R9 mon", v, 0);
    rd(cfg_addr(0), v); chk("R9 cfg0", v, 0);
    chk("R9 irq_out", 32'(irq_out), 0);

    // sweep of every code on every pin: R2 R3 R4 R11
    for (int ci = 0; ci < 9; ci++) begin
      for (int p = 0; p < NP; p++) begin
        logic [5:0] c;
        bit m;
        c = codes[ci];
        wr(cfg_addr(p), 32'hFFFF_FFC0 | 32'(c));
        rd(cfg_addr(p), v); chk("R2 cfg readback", v, 32'(c));
        irq_pin = '0;
        tick(4);
        wr(12'h100, 32'hFF);
        m = lvl_hit(c, 1'b0);
        rd(12'h100, v); chk("R3 R4 R11 after clear low", v, 32'(m) << p);
        irq_pin[p] = 1'b1;
        tick(5);
        m = m | edge_hit(c, 1'b0, 1'b1) | lvl_hit(c, 1'b1);
        rd(12'h100, v); chk("R2 R11 after rise", v, 32'(m) << p);
        chk("R8 outputs masked", 32'(irq_out), 0);
        wr(12'h100, 32'hFF);
        m = lvl_hit(c, 1'b1);
        rd(12'h100, v); chk("R3 R4 after clear high", v, 32'(m) << p);
        irq_pin[p] = 1'b0;
        tick(5);
        m = m | edge_hit(c, 1'b1, 1'b0) | lvl_hit(c, 1'b0);
        rd(12'h100, v); chk("R2 R11 after fall", v, 32'(m) << p);
        wr(cfg_addr(p), 32'h0);
        wr(12'h100, 32'hFF);
        rd(12'h100, v); chk("R5 cleared", v, 0);
      end
    end

    // R1 monitor latency
    tick(3);
    irq_pin[3] = 1'b1;
    rd(12'h104, v); chk("R1 mon edge1", v, 0);
    rd(12'h104, v); chk("R1 mon edge2", v, 0);
    rd(12'h104, v); chk("R1 mon edge3", v, 32'h08);
    irq_pin[3] = 1'b0;
    tick(4);

    // enable, gating, W1C: R5 R6 R7 R8
    wr(cfg_addr(1), 32'h08);
    wr(cfg_addr(6), 32'h02);
    irq_pin[1] = 1'b1;
    tick(5);
    rd(12'h100, v); chk("R4 rise det", v, 32'h02);
    rd(12'h000, v); chk("R8 req masked", v, 0);
    wr(12'h008, 32'h02);
    rd(12'h004, v); chk("R6 en set", v, 32'h02);
    chk("R8 irq_out on", 32'(irq_out), 32'h02);
    rd(12'h000, v); chk("R8 req on", v, 32'h02);
    wr(12'h008, 32'h08);
    rd(12'h004, v); chk("R6 en keep", v, 32'h0A);
    wr(12'h008, 32'h00);
    rd(12'h004, v); chk("R6 zero no effect", v, 32'h0A);
    wr(12'h004, 32'h02);
    rd(12'h004, v); chk("R7 en clr", v, 32'h08);
    chk("R8 irq_out off", 32'(irq_out), 0);
    rd(12'h100, v); chk("R7 det kept", v, 32'h02);
    wr(12'h004, 32'h00);
    rd(12'h004, v); chk("R7 zero no effect", v, 32'h08);
    irq_pin[6] = 1'b1;
    tick(5);
    wr(12'h008, 32'h40);
    chk("R8 irq_out pin6", 32'(irq_out), 32'h40);
    wr(12'h100, 32'h40);
    rd(12'h100, v); chk("R3 R5 level holds", v, 32'h42);
    wr(12'h100, 32'h02);
    rd(12'h100, v); chk("R5 edge cleared", v, 32'h40);
    wr(12'h008, 32'h02);
    chk("R8 irq_out after clr", 32'(irq_out), 32'h40);
    rd(12'h000, v); chk("R8 req after clr", v, 32'h40);
    irq_pin[6] = 1'b0;
    tick(4);
    wr(12'h100, 32'h40);
    rd(12'h100, v); chk("R5 all clear", v, 0);
    chk("R8 irq_out idle", 32'(irq_out), 0);

    // R10 unmapped reads
    rd(12'h00C, v); chk("R10 unmapped", v, 0);
    rd(12'h1A0, v); chk("R10 slot beyond", v, 0);
    rd(12'h185, v); chk("R10 misaligned", v, 0);
    rd(12'h008, v); chk("R10 set reg reads zero", v, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule